// File: doc/BRIEF.md
# Multiword DMA Host Sequencer for a 16-bit ATA Bus

This block is the host side of a multiword DMA transfer on a 16-bit parallel ATA bus. A controller gives it a direction and a word count and pulses `start`. The sequencer then waits for the device to raise its DMA request. It answers with the acknowledge line and moves one 16-bit word per read or write strobe pulse. Read words go into a read buffer, and write words come out of a write buffer.

A burst can end in three ways. The device can drop its request during a strobe pulse, and the word of that pulse still counts. The host ends the burst itself when the word count runs out. The host also ends the burst when the buffer on its side cannot take or give the next word. After a burst that ended early, the sequencer waits for the request to return and goes on, until the full count has moved. It then raises `done`.

Every bus interval is a whole number of cycles of the timing clock, set by parameters:

| Parameter | Meaning |
|-----------|---------|
| `T_SETUP` | Acknowledge-to-strobe setup |
| `T_ACT` | Strobe low width |
| `T_NEG` | Strobe high width between pulses, 2 or more |
| `T_HOLD` | Minimum strobe-to-acknowledge hold |

The defaults of 1, 4, 2 and 1 give a 125 ns strobe cycle at 48 MHz. That is above the 120 ns minimum cycle.

Top module: `mdma_host_engine`

## Requirements
- R1: While `rst` is high, and afterwards until a command starts, `dmack_n`, `dior_n` and `diow_n` are 1 (negated), and `dd_oe`, `done`, `wbuf_pop` and `rbuf_push` are 0.
- R2: `dmack_n` goes to 0 only in the cycle after `dmarq` was sampled 1, and never before a command starts. The first strobe of a burst falls exactly `T_SETUP` cycles after `dmack_n` falls.
- R3: Each strobe pulse moves one 16-bit word and stays low for exactly `T_ACT` cycles. Within a burst, consecutive pulses are separated by exactly `T_NEG` high cycles. A read word is taken from `dd_in` with `rbuf_push` in the last low cycle of its pulse. A write word is held on `dd_out` over its whole pulse.
- R4: With `dir_read` = 1 the block uses only `dior_n` and fills the read buffer. With `dir_read` = 0 it uses only `diow_n` and drains the write buffer. A strobe is never low while `dmack_n` is 1.
- R5: If `dmarq` is 0 in the last low cycle of a pulse, that word still counts, no further pulse follows in that burst, and `dmack_n` returns to 1 at least `T_HOLD` cycles after the strobe rises. With device bursts of B words and a count of N, the command takes ceil(N/B) bursts.
- R6: After a burst that ended early, the block waits with `dmack_n` = 1 until `dmarq` is 1 again and then continues. The number of pulses in a command equals `word_count`, and the data keeps its order across bursts.
- R7: A new word is started only when the buffer side is ready (`rbuf_ready` = 1 for reads, `wbuf_valid` = 1 for writes) and `dmarq` is 1. Otherwise the host ends the burst after the previous pulse. `wbuf_pop` is 1 only while `wbuf_valid` is 1.
- R8: `done` rises in the same cycle that `dmack_n` returns to 1 after the last word. It stays 1 until the next `start`, and it is 0 in the cycle after a `start` with a nonzero count. A `start` with `word_count` = 0 raises `done` in the next cycle with no pulse.
- R9: A `start` while a command is in progress is ignored, so the running command moves exactly its original count.
- R10: `dd_oe` is 1 only with `dir_read` = 0 while `dmack_n` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a command (taken when idle or done) |
| dir_read | input | 1 | 1 = read from device, 0 = write to device |
| word_count | input | CNT_W | Number of 16-bit words in the command |
| done | output | 1 | Command complete |
| dmarq | input | 1 | Device DMA request, active high |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_in | input | WORD_W | Data bus as seen from the device |
| dd_out | output | WORD_W | Data bus value driven in writes |
| dd_oe | output | 1 | Data bus output enable |
| wbuf_valid | input | 1 | Write buffer holds a word |
| wbuf_data | input | WORD_W | Write buffer head word |
| wbuf_pop | output | 1 | Take the head word from the write buffer |
| rbuf_ready | input | 1 | Read buffer can take a word |
| rbuf_data | output | WORD_W | Word for the read buffer |
| rbuf_push | output | 1 | Write `rbuf_data` into the read buffer |

## Verification
The bench sweeps both directions over word counts 1, 2, 3, 5 and 8, and over device burst lengths 1, 2, 3 and 100. The word counts separate the one-word case from multiword bursts. The burst lengths separate device-ended bursts from bursts the host ends when the count runs out, and the expected burst count ceil(N/B) tells them apart. Further runs in both directions stall the buffer side periodically, so the host has to end bursts itself and resume. These runs check ordered data, pulse totals and exact strobe widths. A zero count and a second `start` in the middle of a command cover the edges of the command interface.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_ACT,
        ST_NEG,
        ST_ARM,
        ST_HOLD,
        ST_DONE
    } mdma_state_e;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic ack;
        logic rd_strobe;
        logic wr_strobe;
        logic drive;
    } bus_ctl_t;

    function automatic logic in_burst(input mdma_state_e st);
        return (st == ST_SETUP) || (st == ST_ACT) || (st == ST_NEG) ||
               (st == ST_ARM) || (st == ST_HOLD);
    endfunction

    function automatic bus_ctl_t decode_bus(input mdma_state_e st, input xfer_dir_e dir);
        bus_ctl_t c;
        c.ack       = in_burst(st);
        c.rd_strobe = (st == ST_ACT) && (dir == DIR_READ);
        c.wr_strobe = (st == ST_ACT) && (dir == DIR_WRITE);
        c.drive     = in_burst(st) && (dir == DIR_WRITE);
        return c;
    endfunction

    function automatic logic side_ready(input xfer_dir_e dir, input logic rd_space,
                                        input logic wr_avail);
        return (dir == DIR_READ) ? rd_space : wr_avail;
    endfunction

endpackage

// File: rtl/mdma_timer.sv
module mdma_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // A load of N makes the owning state last N cycles (N >= 1).
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/mdma_word_ctr.sv
module mdma_word_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last,
    output logic         empty
);
    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= load_val;
        else if (dec && left != '0)
            left <= left - 1'b1;
    end

    assign last  = (left == W'(1));
    assign empty = (left == '0);
endmodule

// File: rtl/mdma_host_engine.sv
module mdma_host_engine
    import mdma_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int CNT_W   = 16,
    parameter int T_SETUP = 1,
    parameter int T_ACT   = 4,
    parameter int T_NEG   = 2,
    parameter int T_HOLD  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_read,
    input  logic [CNT_W-1:0]  word_count,
    output logic              done,
    input  logic              dmarq,
    output logic              dmack_n,
    output logic              dior_n,
    output logic              diow_n,
    input  logic [WORD_W-1:0] dd_in,
    output logic [WORD_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic              wbuf_valid,
    input  logic [WORD_W-1:0] wbuf_data,
    output logic              wbuf_pop,
    input  logic              rbuf_ready,
    output logic [WORD_W-1:0] rbuf_data,
    output logic              rbuf_push
);
    localparam int T_MAX_A = (T_SETUP > T_ACT) ? T_SETUP : T_ACT;
    localparam int T_MAX_B = (T_NEG > T_HOLD) ? T_NEG : T_HOLD;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int TMR_W   = $clog2(T_MAX + 1);

    localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(T_SETUP);
    localparam logic [TMR_W-1:0] LD_ACT   = TMR_W'(T_ACT);
    // One high cycle of the gap is spent in ST_ARM with the next word on the bus.
    localparam logic [TMR_W-1:0] LD_NEG   = TMR_W'(T_NEG - 1);
    localparam logic [TMR_W-1:0] LD_HOLD  = TMR_W'(T_HOLD);

    mdma_state_e       state, state_n;
    xfer_dir_e         dir_q;
    logic [WORD_W-1:0] wdata_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              ctr_load, ctr_dec;
    logic              last_word, all_moved;
    logic              data_load;
    logic              side_ok;
    bus_ctl_t          bus;

    mdma_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    mdma_word_ctr #(.W(CNT_W)) u_words (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (word_count),
        .dec      (ctr_dec),
        .last     (last_word),
        .empty    (all_moved)
    );

    assign side_ok = side_ready(dir_q, rbuf_ready, wbuf_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dir_q   <= DIR_WRITE;
            wdata_q <= '0;
        end else begin
            state <= state_n;
            if (ctr_load)
                dir_q <= dir_read ? DIR_READ : DIR_WRITE;
            if (data_load)
                wdata_q <= wbuf_data;
        end
    end

    always_comb begin
        state_n   = state;
        tmr_load  = 1'b0;
        tmr_val   = LD_SETUP;
        ctr_load  = 1'b0;
        ctr_dec   = 1'b0;
        data_load = 1'b0;
        wbuf_pop  = 1'b0;
        rbuf_push = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                // R9: start is only taken here, never inside a command
                if (start) begin
                    ctr_load = 1'b1;
                    state_n  = (word_count == '0) ? ST_DONE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                // R2/R7: acknowledge only on a seen request with the buffer ready
                if (dmarq && side_ok) begin
                    state_n   = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                    data_load = (dir_q == DIR_WRITE);
                    wbuf_pop  = (dir_q == DIR_WRITE);
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_n  = ST_ACT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACT;
                end
            end
            ST_ACT: begin
                if (tmr_done) begin
                    ctr_dec   = 1'b1;
                    rbuf_push = (dir_q == DIR_READ);
                    tmr_load  = 1'b1;
                    // R5: a dropped request during the pulse ends the burst after this word
                    if (last_word || !dmarq) begin
                        state_n = ST_HOLD;
                        tmr_val = LD_HOLD;
                    end else begin
                        state_n = ST_NEG;
                        tmr_val = LD_NEG;
                    end
                end
            end
            ST_NEG: begin
                if (tmr_done) begin
                    if (dmarq && side_ok) begin
                        state_n   = ST_ARM;
                        data_load = (dir_q == DIR_WRITE);
                        wbuf_pop  = (dir_q == DIR_WRITE);
                    end else begin
                        state_n  = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = LD_HOLD;
                    end
                end
            end
            ST_ARM: begin
                state_n  = ST_ACT;
                tmr_load = 1'b1;
                tmr_val  = LD_ACT;
            end
            ST_HOLD: begin
                if (tmr_done)
                    state_n = all_moved ? ST_DONE : ST_WAIT;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign bus       = decode_bus(state, dir_q);
    assign dmack_n   = !bus.ack;
    assign dior_n    = !bus.rd_strobe;
    assign diow_n    = !bus.wr_strobe;
    assign dd_oe     = bus.drive;
    assign dd_out    = wdata_q;
    assign rbuf_data = dd_in;
    assign done      = (state == ST_DONE);
endmodule

// File: rtl/mdma_host_checker.sv
module mdma_host_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dmarq,
    input logic              dmack_n,
    input logic              dior_n,
    input logic              diow_n,
    input logic              dd_oe,
    input logic [WORD_W-1:0] dd_out,
    input logic              wbuf_pop,
    input logic              wbuf_valid,
    input logic              rbuf_push,
    input logic              done
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (dmack_n && dior_n && diow_n && !done && !dd_oe));

    assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(dmack_n) |-> $past(dmarq));

    assert_strobe_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(dior_n) || $fell(diow_n)) |-> $past(!dmack_n));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    assert_push_at_negation_R3: assert property (@(posedge clk) disable iff (rst)
        rbuf_push |=> $rose(dior_n));

    assert_write_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!diow_n && $past(!diow_n)) |-> $stable(dd_out));

    assert_pop_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
        wbuf_pop |-> wbuf_valid);

    assert_drive_window_R10: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> (!dmack_n && dior_n));

    assert_done_bus_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (dmack_n && dior_n && diow_n && !dd_oe));
endmodule

bind mdma_host_engine mdma_host_checker #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dmarq      (dmarq),
    .dmack_n    (dmack_n),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .dd_oe      (dd_oe),
    .dd_out     (dd_out),
    .wbuf_pop   (wbuf_pop),
    .wbuf_valid (wbuf_valid),
    .rbuf_push  (rbuf_push),
    .done       (done)
);

// File: tb/tb_mdma_host_engine.sv
module tb_mdma_host_engine;
    localparam int P_SETUP = 2;
    localparam int P_ACT   = 3;
    localparam int P_NEG   = 3;
    localparam int P_HOLD  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dir_read = 1'b0;
    logic [15:0] word_count = '0;
    logic        done;
    logic        dmarq = 1'b0;
    logic        dmack_n, dior_n, diow_n;
    logic [15:0] dd_in = '0;
    logic [15:0] dd_out;
    logic        dd_oe;
    logic        wbuf_valid = 1'b1;
    logic [15:0] wbuf_data;
    logic        wbuf_pop;
    logic        rbuf_ready = 1'b1;
    logic [15:0] rbuf_data;
    logic        rbuf_push;

    mdma_host_engine #(
        .T_SETUP(P_SETUP), .T_ACT(P_ACT), .T_NEG(P_NEG), .T_HOLD(P_HOLD)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .dir_read(dir_read),
        .word_count(word_count), .done(done), .dmarq(dmarq),
        .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n),
        .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
        .wbuf_valid(wbuf_valid), .wbuf_data(wbuf_data), .wbuf_pop(wbuf_pop),
        .rbuf_ready(rbuf_ready), .rbuf_data(rbuf_data), .rbuf_push(rbuf_push)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    // device and buffer model state
    bit dev_en = 1'b0;
    bit stall = 1'b0;
    int burst_len = 1;
    int bcnt = 0, gap = 0;
    int falls = 0, rises = 0, pushes = 0, pop_idx = 0, bursts = 0;
    int mism = 0, terr = 0, oe_err = 0, pop_err = 0, rogue = 0, wrongdir = 0;
    int base_fall = 0, base_rise = 0, base_push = 0, base_pop = 0;
    int t_ack = 0, t_fall = 0, t_rise = 0, t_ackrise = -1;
    bit first = 1'b0;
    logic prev_ack = 1'b1, prev_s = 1'b1;

    function automatic logic [15:0] pat(input int i, input bit rd);
        logic [31:0] v;
        v = rd ? (32'h3C00 + 32'(i) * 32'd37) : (32'hC35A ^ (32'(i) * 32'd1021));
        return v[15:0];
    endfunction

    assign wbuf_data = pat(pop_idx - base_pop, 1'b0);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wbuf_pop) pop_idx <= pop_idx + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device, buffer and timing monitor, all evaluated away from the active edge.
    always @(negedge clk) begin
        logic s;
        bit ack_fall, ack_rise, s_fall, s_rise;
        s = dior_n & diow_n;
        ack_fall = prev_ack && !dmack_n;
        ack_rise = !prev_ack && dmack_n;
        s_fall = prev_s && !s;
        s_rise = !prev_s && s;
        stall_drive(cyc);
        if (!dmack_n && !dior_n && !diow_n) rogue++;
        if (dmack_n && !s) rogue++;
        if (dd_oe && (dmack_n || dir_read)) oe_err++;
        if (wbuf_pop && !wbuf_valid) pop_err++;
        if (ack_fall) begin
            t_ack = cyc; first = 1'b1; bursts++;
        end
        if (s_fall) begin
            if (first) begin
                if (cyc - t_ack != P_SETUP) terr++;
                first = 1'b0;
            end else if (cyc - t_rise != P_NEG) terr++;
            t_fall = cyc;
            if (dir_read ? !diow_n : !dior_n) wrongdir++;
            dd_in = pat(falls - base_fall, 1'b1);
            falls++;
            bcnt++;
            if (dev_en && bcnt >= burst_len) dmarq = 1'b0;
        end
        if (s_rise) begin
            if (cyc - t_fall != P_ACT) terr++;
            t_rise = cyc;
            if (!dir_read && (dd_out != pat(rises - base_rise, 1'b0) || !dd_oe)) mism++;
            rises++;
        end
        if (rbuf_push) begin
            if (rbuf_data != pat(pushes - base_push, 1'b1)) mism++;
            pushes++;
        end
        if (ack_rise) begin
            if (cyc - t_rise < P_HOLD) terr++;
            t_ackrise = cyc;
            bcnt = 0;
        end
        if (!dev_en) begin
            dmarq = 1'b0; bcnt = 0; gap = 0;
        end else if (!dmarq && dmack_n) begin
            gap++;
            if (gap >= 4) begin
                dmarq = 1'b1; gap = 0; bcnt = 0;
            end
        end
        prev_ack = dmack_n;
        prev_s = s;
    end

    task automatic stall_drive(input int c);
        rbuf_ready = stall ? ((c % 5) >= 2) : 1'b1;
        wbuf_valid = stall ? ((c % 7) >= 3) : 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic run(input bit rd, input int n, input int bl, input bit stl, input bit restart);
        int f0, m0, t0, o0, p0, r0, w0, b0, waited, exp_b;
        string tag;
        tag = rd ? "read" : "write";
        base_fall = falls; base_rise = rises; base_push = pushes; base_pop = pop_idx;
        f0 = falls; m0 = mism; t0 = terr; o0 = oe_err; p0 = pop_err;
        r0 = rogue; w0 = wrongdir; b0 = bursts;
        dir_read = rd; burst_len = bl; stall = stl; dev_en = 1'b1;
        start = 1'b1; word_count = 16'(n);
        step();
        start = 1'b0;
        if (n == 0) begin
            check(done == 1'b1, "R8 zero count done", int'(done), 1);
        end else begin
            check(done == 1'b0, "R8 done cleared by start", int'(done), 0);
        end
        if (restart) begin
            repeat (15) step();
            start = 1'b1; word_count = 16'(n + 4);
            step();
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20000) begin
            step();
            waited++;
        end
        check(done == 1'b1, "R8 done reached", int'(done), 1);
        if (n > 0) check(t_ackrise == cyc, "R8 done with ack negation", t_ackrise, cyc);
        check(falls - f0 == n, restart ? "R9 pulses after ignored start" : "R6 pulse total",
              falls - f0, n);
        check(mism == m0, {"R3 data order ", tag}, mism - m0, 0);
        check(terr == t0, "R3 R2 R5 strobe timing", terr - t0, 0);
        check(wrongdir == w0 && rogue == r0, "R4 strobe choice", wrongdir - w0 + rogue - r0, 0);
        check(oe_err == o0, "R10 drive window", oe_err - o0, 0);
        check(pop_err == p0, "R7 pop without data", pop_err - p0, 0);
        if (n > 0) begin
            exp_b = (n + bl - 1) / bl;
            if (!stl)
                check(bursts - b0 == exp_b, "R5 burst count", bursts - b0, exp_b);
            else
                check(bursts - b0 >= exp_b, "R7 host-ended bursts", bursts - b0, exp_b);
        end
        repeat (4) step();
        check(done == 1'b1, "R8 done held", int'(done), 1);
        dev_en = 1'b0; stall = 1'b0;
        repeat (2) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) step();
        check(dmack_n && dior_n && diow_n, "R1 bus idle in reset", int'({dmack_n, dior_n, diow_n}), 7);
        check(!dd_oe && !done && !wbuf_pop && !rbuf_push, "R1 outputs low in reset",
              int'({dd_oe, done, wbuf_pop, rbuf_push}), 0);
        rst = 1'b0;
        dev_en = 1'b1;
        repeat (10) step();
        check(dmarq == 1'b1, "R2 model request up", int'(dmarq), 1);
        check(dmack_n == 1'b1 && done == 1'b0, "R2 no ack without command",
              int'({dmack_n, done}), 2);
        dev_en = 1'b0;
        repeat (2) step();
        run(1'b0, 0, 1, 1'b0, 1'b0);
        for (int d = 0; d < 2; d++) begin
            for (int ni = 0; ni < 5; ni++) begin
                for (int bi = 0; bi < 4; bi++) begin
                    int nn, bb;
                    nn = (ni == 0) ? 1 : (ni == 1) ? 2 : (ni == 2) ? 3 : (ni == 3) ? 5 : 8;
                    bb = (bi == 3) ? 100 : bi + 1;
                    run(d[0], nn, bb, 1'b0, 1'b0);
                end
            end
        end
        run(1'b1, 9, 100, 1'b1, 1'b0);
        run(1'b0, 9, 100, 1'b1, 1'b0);
        run(1'b1, 10, 3, 1'b1, 1'b0);
        run(1'b0, 10, 3, 1'b1, 1'b0);
        run(1'b1, 12, 100, 1'b0, 1'b1);
        run(1'b0, 12, 5, 1'b0, 1'b1);
        run(1'b1, 0, 1, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule